// File: doc/BRIEF.md
# Branch Misprediction Resolution Unit

This execute-stage block receives one resolved instruction per cycle with its class flags, predicted direction, mispredict flag and fault flag. It decides, for each instruction, whether to signal normal completion, raise a trap, flag an illegal operation, or squash the younger part of the pipeline and steer fetch to a corrected address. The branch outcome itself is computed elsewhere and arrives here as the mispredict flag and the two candidate fetch addresses.

The squash boundary and the redirect address follow delay-slot rules. A direct conditional branch that owns a delay slot squashes from its own sequence number and refetches at the next PC. Any other direct branch, and every indirect transfer, squashes after the slot (sequence number plus one) and refetches at the PC after the next one. Two saturating counters record mispredictions: one for a predicted-taken direction and one for a predicted-not-taken direction.

All results are registered and appear one clock after the input that caused them.

Top module: `branch_resolve_unit`

## Requirements
- R1: An instruction with `in_is_mem` set raises `illegal` and nothing else: no done, no trap, no squash, no counter change. This holds whatever its other flags say.
- R2: A mispredicted, fault-free, direct control instruction with `in_cond_ds` set squashes with boundary equal to `in_seq` and redirect equal to `in_next_pc`, for either predicted direction.
- R3: `keep_slot` is 1 only for the R2 case when the prediction was not-taken (`in_pred_taken` = 0). It is 0 for every other result.
- R4: A mispredicted, fault-free, direct control instruction without `in_cond_ds` squashes with boundary `in_seq + 1` (modulo 2^SEQ_W) and redirect `in_next2_pc`.
- R5: A mispredicted, fault-free, indirect control instruction (with `in_is_direct` = 0) squashes with boundary `in_seq + 1` (modulo 2^SEQ_W) and redirect `in_next2_pc`.
- R6: A squash asserts `sq_valid` and `done` for exactly one cycle per causing input, and carries `in_tid` on `sq_tid` and `in_stage` on `sq_stage`. When there is no squash, the boundary, redirect, tid and stage outputs are 0.
- R7: Each squash increments `cnt_taken_miss` if the prediction was taken, otherwise `cnt_ntaken_miss`. Neither counter changes without a squash.
- R8: The counters are CNT_W bits wide (default 32), hold at all-ones once reached, and clear to 0 while `rst_n` is low.
- R9: A control instruction with `in_fault` set produces no done, no squash, no trap and no error.
- R10: A non-control, non-memory instruction with `in_fault` set (and no mispredict flag) raises `trap` with its thread on `trap_tid`, and no done.
- R11: A fault-free non-control instruction, or a fault-free control instruction without mispredict, raises `done` only.
- R12: A mispredict flag on an instruction that is neither direct nor indirect control raises `illegal` and nothing else. This includes non-control instructions.
- R13: Every output is registered and follows its input by one cycle. A cycle with `in_valid` low yields no done, trap, illegal or squash in the next cycle. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_tid | input | TID_W | Thread id |
| in_seq | input | SEQ_W | Instruction sequence number |
| in_is_mem | input | 1 | Memory reference instruction |
| in_is_ctrl | input | 1 | Control-flow instruction |
| in_is_direct | input | 1 | Direct (PC-relative) transfer |
| in_is_indirect | input | 1 | Register-target transfer |
| in_cond_ds | input | 1 | Conditional branch with delay slot |
| in_pred_taken | input | 1 | Predicted direction was taken |
| in_mispred | input | 1 | Resolution disagreed with prediction |
| in_fault | input | 1 | Execution faulted |
| in_next_pc | input | PC_W | Next PC |
| in_next2_pc | input | PC_W | PC after the next PC |
| in_stage | input | STG_W | Pipeline stage of this unit |
| sq_valid | output | 1 | Squash request pulse |
| sq_tid | output | TID_W | Thread to squash |
| sq_boundary | output | SEQ_W | Sequence number from which younger work is squashed |
| redirect_pc | output | PC_W | Corrected fetch address |
| keep_slot | output | 1 | Delay slot instruction must still be processed |
| sq_stage | output | STG_W | Stage that initiated the squash |
| done | output | 1 | Instruction completed |
| trap | output | 1 | Trap request |
| trap_tid | output | TID_W | Thread of the trap |
| illegal | output | 1 | Illegal operation for this unit |
| cnt_taken_miss | output | CNT_W | Mispredictions with taken prediction |
| cnt_ntaken_miss | output | CNT_W | Mispredictions with not-taken prediction |

## Verification
Every result (squash, boundary, redirect, keep flag, done, trap, illegal and both counters) is due exactly one rising edge after the cycle that carried the input. The driver applies an input on a falling edge and pushes the full expected output set for that cycle into a queue. Idle cycles also push an all-quiet expectation. The monitor samples one nanosecond after the next rising edge and pops one item per edge, so each comparison is tied to the single edge that registers the result. Reset-state checks are taken directly while reset is held, with the queue drained beforehand.

// File: rtl/brres_pkg.sv
// Package: shared encodings for the branch resolution unit.
// Assumes: one resolved instruction per cycle, no internal storage beyond output flops.
package brres_pkg;

    // Outcome chosen for one input instruction
    typedef enum logic [2:0] {
        OUT_NONE    = 3'd0,
        OUT_DONE    = 3'd1,
        OUT_SQUASH  = 3'd2,
        OUT_TRAP    = 3'd3,
        OUT_ILLEGAL = 3'd4
    } outcome_e;

    // Where the squash boundary sits relative to the branch
    typedef enum logic {
        CUT_AFTER_SLOT = 1'b0,
        CUT_AT_BRANCH  = 1'b1
    } cut_e;

endpackage

// File: rtl/brres_classify.sv
// Module: brres_classify
// Purpose: purely combinational decision of the outcome for the current
// input instruction, and of the delay-slot handling on a misprediction.
// Assumes: when both direct and indirect are set, direct takes precedence.
module brres_classify
    import brres_pkg::*;
(
    input  logic     valid,
    input  logic     is_mem,
    input  logic     is_ctrl,
    input  logic     is_direct,
    input  logic     is_indirect,
    input  logic     cond_ds,
    input  logic     pred_taken,
    input  logic     mispred,
    input  logic     fault,
    output outcome_e outcome,
    output cut_e     cut,
    output logic     keep_ds
);

    // Priority decision: memory ops, then control, then plain ALU work
    always_comb begin
        outcome = OUT_NONE;
        cut     = CUT_AFTER_SLOT;
        keep_ds = 1'b0;
        if (!valid) begin
            outcome = OUT_NONE;
        end else if (is_mem) begin
            outcome = OUT_ILLEGAL;
        end else if (is_ctrl) begin
            if (fault) begin
                outcome = OUT_NONE;
            end else if (!mispred) begin
                outcome = OUT_DONE;
            end else if (is_direct) begin
                outcome = OUT_SQUASH;
                if (cond_ds) begin
                    cut     = CUT_AT_BRANCH;
                    keep_ds = !pred_taken;
                end
            end else if (is_indirect) begin
                outcome = OUT_SQUASH;
            end else begin
                outcome = OUT_ILLEGAL;
            end
        end else begin
            if (mispred) begin
                outcome = OUT_ILLEGAL;
            end else if (fault) begin
                outcome = OUT_TRAP;
            end else begin
                outcome = OUT_DONE;
            end
        end
    end

endmodule

// File: rtl/brres_target_sel.sv
// Module: brres_target_sel
// Purpose: picks the squash boundary and the refetch address from the cut
// position. Assumes sequence numbers wrap modulo 2^SEQ_W.
module brres_target_sel
    import brres_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32
) (
    input  cut_e              cut,
    input  logic [SEQ_W-1:0]  seq,
    input  logic [PC_W-1:0]   next_pc,
    input  logic [PC_W-1:0]   next2_pc,
    output logic [SEQ_W-1:0]  boundary,
    output logic [PC_W-1:0]   target
);

    localparam logic [SEQ_W-1:0] SEQ_ONE = SEQ_W'(1);

    // Boundary and target selection by cut position
    always_comb begin
        if (cut == CUT_AT_BRANCH) begin
            boundary = seq;
            target   = next_pc;
        end else begin
            boundary = seq + SEQ_ONE;
            target   = next2_pc;
        end
    end

endmodule

// File: rtl/brres_sat_counter.sv
// Module: brres_sat_counter
// Purpose: W-bit event counter that stops at all-ones.
// Assumes: at most one increment per cycle; synchronous active-low clear.
module brres_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] ONE = W'(1);

    // Count up on inc unless already at the top value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != TOP)) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/branch_resolve_unit.sv
// Module: branch_resolve_unit
// Purpose: resolves one instruction per cycle into done, trap, illegal or a
// squash with redirect, and counts mispredictions by predicted direction.
// Assumes: branch outcome and both candidate PCs are computed upstream;
// every output is registered with one cycle of latency.
module branch_resolve_unit
    import brres_pkg::*;
#(
    parameter int TID_W = 2,
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int STG_W = 3,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [TID_W-1:0] in_tid,
    input  logic [SEQ_W-1:0] in_seq,
    input  logic             in_is_mem,
    input  logic             in_is_ctrl,
    input  logic             in_is_direct,
    input  logic             in_is_indirect,
    input  logic             in_cond_ds,
    input  logic             in_pred_taken,
    input  logic             in_mispred,
    input  logic             in_fault,
    input  logic [PC_W-1:0]  in_next_pc,
    input  logic [PC_W-1:0]  in_next2_pc,
    input  logic [STG_W-1:0] in_stage,
    output logic             sq_valid,
    output logic [TID_W-1:0] sq_tid,
    output logic [SEQ_W-1:0] sq_boundary,
    output logic [PC_W-1:0]  redirect_pc,
    output logic             keep_slot,
    output logic [STG_W-1:0] sq_stage,
    output logic             done,
    output logic             trap,
    output logic [TID_W-1:0] trap_tid,
    output logic             illegal,
    output logic [CNT_W-1:0] cnt_taken_miss,
    output logic [CNT_W-1:0] cnt_ntaken_miss
);

    localparam int NUM_CNT = 2;
    localparam int IDX_TAKEN = 0;
    localparam int IDX_NTAKEN = 1;

    outcome_e         outcome;
    cut_e             cut;
    logic             keep_ds;
    logic [SEQ_W-1:0] boundary_c;
    logic [PC_W-1:0]  target_c;
    logic             is_squash;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_val [NUM_CNT];

    brres_classify u_classify (
        .valid       (in_valid),
        .is_mem      (in_is_mem),
        .is_ctrl     (in_is_ctrl),
        .is_direct   (in_is_direct),
        .is_indirect (in_is_indirect),
        .cond_ds     (in_cond_ds),
        .pred_taken  (in_pred_taken),
        .mispred     (in_mispred),
        .fault       (in_fault),
        .outcome     (outcome),
        .cut         (cut),
        .keep_ds     (keep_ds)
    );

    brres_target_sel #(
        .SEQ_W (SEQ_W),
        .PC_W  (PC_W)
    ) u_target (
        .cut      (cut),
        .seq      (in_seq),
        .next_pc  (in_next_pc),
        .next2_pc (in_next2_pc),
        .boundary (boundary_c),
        .target   (target_c)
    );

    // Squash strobe and per-direction increment requests
    always_comb begin
        is_squash           = (outcome == OUT_SQUASH);
        cnt_inc[IDX_TAKEN]  = is_squash && in_pred_taken;
        cnt_inc[IDX_NTAKEN] = is_squash && !in_pred_taken;
    end

    // One saturating counter per predicted direction
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        brres_sat_counter #(
            .W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[g]),
            .count (cnt_val[g])
        );
    end

    assign cnt_taken_miss  = cnt_val[IDX_TAKEN];
    assign cnt_ntaken_miss = cnt_val[IDX_NTAKEN];

    // Output register stage: strobes pulse, data fields zero when unused
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_valid    <= 1'b0;
            sq_tid      <= '0;
            sq_boundary <= '0;
            redirect_pc <= '0;
            keep_slot   <= 1'b0;
            sq_stage    <= '0;
            done        <= 1'b0;
            trap        <= 1'b0;
            trap_tid    <= '0;
            illegal     <= 1'b0;
        end else begin
            sq_valid    <= is_squash;
            sq_tid      <= is_squash ? in_tid : '0;
            sq_boundary <= is_squash ? boundary_c : '0;
            redirect_pc <= is_squash ? target_c : '0;
            keep_slot   <= is_squash && keep_ds;
            sq_stage    <= is_squash ? in_stage : '0;
            done        <= (outcome == OUT_DONE) || is_squash;
            trap        <= (outcome == OUT_TRAP);
            trap_tid    <= (outcome == OUT_TRAP) ? in_tid : '0;
            illegal     <= (outcome == OUT_ILLEGAL);
        end
    end

endmodule

// File: rtl/brres_checker.sv
// Module: brres_checker
// Purpose: temporal properties of branch_resolve_unit, attached by bind.
// Assumes: same parameters and port names as the top module.
module brres_checker #(
    parameter int TID_W = 2,
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int STG_W = 3,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [TID_W-1:0] in_tid,
    input logic [SEQ_W-1:0] in_seq,
    input logic             in_is_mem,
    input logic             in_is_ctrl,
    input logic             in_is_direct,
    input logic             in_is_indirect,
    input logic             in_cond_ds,
    input logic             in_pred_taken,
    input logic             in_mispred,
    input logic             in_fault,
    input logic [PC_W-1:0]  in_next_pc,
    input logic [PC_W-1:0]  in_next2_pc,
    input logic [STG_W-1:0] in_stage,
    input logic             sq_valid,
    input logic [TID_W-1:0] sq_tid,
    input logic [SEQ_W-1:0] sq_boundary,
    input logic [PC_W-1:0]  redirect_pc,
    input logic             keep_slot,
    input logic [STG_W-1:0] sq_stage,
    input logic             done,
    input logic             trap,
    input logic [TID_W-1:0] trap_tid,
    input logic             illegal,
    input logic [CNT_W-1:0] cnt_taken_miss,
    input logic [CNT_W-1:0] cnt_ntaken_miss
);

    logic mp_ok;
    assign mp_ok = in_valid && !in_is_mem && in_is_ctrl && !in_fault && in_mispred;

    // R1: memory op yields only the error
    a_r1_mem_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_mem) |=> (illegal && !done && !trap && !sq_valid));

    // R2: delay-slot conditional branch cuts at itself
    a_r2_cut_at_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_ok && in_is_direct && in_cond_ds) |=>
        (sq_valid && sq_boundary == $past(in_seq) && redirect_pc == $past(in_next_pc)));

    // R3: keep flag for not-taken prediction, never without a squash
    a_r3_keep_nt: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_ok && in_is_direct && in_cond_ds && !in_pred_taken) |=> keep_slot);
    a_r3_keep_needs_squash: assert property (@(posedge clk) disable iff (!rst_n)
        keep_slot |-> sq_valid);

    // R5: indirect transfer cuts after the slot
    a_r5_indirect: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_ok && !in_is_direct && in_is_indirect) |=>
        (sq_valid && sq_boundary == SEQ_W'($past(in_seq) + 1'b1)
         && redirect_pc == $past(in_next2_pc)));

    // R6: squash carries thread and stage, and implies done
    a_r6_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_ok && (in_is_direct || in_is_indirect)) |=>
        (sq_tid == $past(in_tid) && sq_stage == $past(in_stage)));
    a_r6_done: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |-> done);

    // R7: counters move only with a squash
    a_r7_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_valid |-> ($stable(cnt_taken_miss) && $stable(cnt_ntaken_miss)));

    // R8: saturation holds
    a_r8_sat_t: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_taken_miss == {CNT_W{1'b1}}) |=> (cnt_taken_miss == {CNT_W{1'b1}}));
    a_r8_sat_n: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_ntaken_miss == {CNT_W{1'b1}}) |=> (cnt_ntaken_miss == {CNT_W{1'b1}}));

    // R10: ALU fault traps with its thread
    a_r10_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_is_mem && !in_is_ctrl && !in_mispred && in_fault) |=>
        (trap && trap_tid == $past(in_tid) && !done));

    // R13: idle cycle gives quiet outputs
    a_r13_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!done && !trap && !illegal && !sq_valid));

endmodule

bind branch_resolve_unit brres_checker #(
    .TID_W (TID_W),
    .SEQ_W (SEQ_W),
    .PC_W  (PC_W),
    .STG_W (STG_W),
    .CNT_W (CNT_W)
) u_brres_checker (.*);

// File: tb/test_branch_resolve_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: driver pushes expectations, monitor pops one per edge.
module test_branch_resolve_unit;

    localparam int TID_W = 2;
    localparam int SEQ_W = 8;
    localparam int PC_W  = 16;
    localparam int STG_W = 3;
    localparam int CNT_W = 3;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [TID_W-1:0] in_tid = '0;
    logic [SEQ_W-1:0] in_seq = '0;
    logic in_is_mem = 1'b0, in_is_ctrl = 1'b0, in_is_direct = 1'b0, in_is_indirect = 1'b0;
    logic in_cond_ds = 1'b0, in_pred_taken = 1'b0, in_mispred = 1'b0, in_fault = 1'b0;
    logic [PC_W-1:0] in_next_pc = '0, in_next2_pc = '0;
    logic [STG_W-1:0] in_stage = '0;
    logic sq_valid, keep_slot, done, trap, illegal;
    logic [TID_W-1:0] sq_tid, trap_tid;
    logic [SEQ_W-1:0] sq_boundary;
    logic [PC_W-1:0] redirect_pc;
    logic [STG_W-1:0] sq_stage;
    logic [CNT_W-1:0] cnt_taken_miss, cnt_ntaken_miss;

    branch_resolve_unit #(
        .TID_W(TID_W), .SEQ_W(SEQ_W), .PC_W(PC_W), .STG_W(STG_W), .CNT_W(CNT_W)
    ) i_branch_resolve_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tid(in_tid), .in_seq(in_seq),
        .in_is_mem(in_is_mem), .in_is_ctrl(in_is_ctrl), .in_is_direct(in_is_direct),
        .in_is_indirect(in_is_indirect), .in_cond_ds(in_cond_ds),
        .in_pred_taken(in_pred_taken), .in_mispred(in_mispred), .in_fault(in_fault),
        .in_next_pc(in_next_pc), .in_next2_pc(in_next2_pc), .in_stage(in_stage),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_boundary(sq_boundary),
        .redirect_pc(redirect_pc), .keep_slot(keep_slot), .sq_stage(sq_stage),
        .done(done), .trap(trap), .trap_tid(trap_tid), .illegal(illegal),
        .cnt_taken_miss(cnt_taken_miss), .cnt_ntaken_miss(cnt_ntaken_miss)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic sq; logic [TID_W-1:0] stid; logic [SEQ_W-1:0] bnd; logic [PC_W-1:0] tgt;
        logic keep; logic [STG_W-1:0] stg; logic dn; logic tr; logic [TID_W-1:0] ttid;
        logic ill; int ct; int cn; string req;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    int mt = 0;
    int mn = 0;
    bit finished = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one instruction and push its expected registered result
    task automatic send(input logic mem, ctrl, dir, ind, cds, pt, mp, flt,
                        input logic [TID_W-1:0] tid, input logic [SEQ_W-1:0] seq,
                        input logic [PC_W-1:0] np, np2, input logic [STG_W-1:0] stg,
                        input string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_is_mem = mem; in_is_ctrl = ctrl; in_is_direct = dir;
        in_is_indirect = ind; in_cond_ds = cds; in_pred_taken = pt; in_mispred = mp;
        in_fault = flt; in_tid = tid; in_seq = seq; in_next_pc = np; in_next2_pc = np2;
        in_stage = stg;
        e = '{sq:0, stid:0, bnd:0, tgt:0, keep:0, stg:0, dn:0, tr:0, ttid:0, ill:0,
              ct:0, cn:0, req:req};
        if (mem) e.ill = 1;
        else if (ctrl) begin
            if (!flt) begin
                if (!mp) e.dn = 1;
                else if (dir || ind) begin
                    e.sq = 1; e.dn = 1; e.stid = tid; e.stg = stg;
                    if (dir && cds) begin e.bnd = seq; e.tgt = np; e.keep = !pt; end
                    else begin e.bnd = seq + 8'd1; e.tgt = np2; end
                    if (pt) begin if (mt < CMAX) mt++; end
                    else begin if (mn < CMAX) mn++; end
                end else e.ill = 1;
            end
        end else begin
            if (mp) e.ill = 1;
            else if (flt) begin e.tr = 1; e.ttid = tid; end
            else e.dn = 1;
        end
        e.ct = mt; e.cn = mn;
        q.push_back(e);
    endtask

    task automatic idle(input string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0;
        e = '{sq:0, stid:0, bnd:0, tgt:0, keep:0, stg:0, dn:0, tr:0, ttid:0, ill:0,
              ct:mt, cn:mn, req:req};
        q.push_back(e);
    endtask

    // Monitor: results are due one edge after the driving negedge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.req, "sq_valid", 32'(sq_valid), 32'(e.sq));
            chk(e.req, "sq_tid", 32'(sq_tid), 32'(e.stid));
            chk(e.req, "sq_boundary", 32'(sq_boundary), 32'(e.bnd));
            chk(e.req, "redirect_pc", 32'(redirect_pc), 32'(e.tgt));
            chk(e.req, "keep_slot", 32'(keep_slot), 32'(e.keep));
            chk(e.req, "sq_stage", 32'(sq_stage), 32'(e.stg));
            chk(e.req, "done", 32'(done), 32'(e.dn));
            chk(e.req, "trap", 32'(trap), 32'(e.tr));
            chk(e.req, "trap_tid", 32'(trap_tid), 32'(e.ttid));
            chk(e.req, "illegal", 32'(illegal), 32'(e.ill));
            chk(e.req, "cnt_taken_miss", 32'(cnt_taken_miss), 32'(e.ct));
            chk(e.req, "cnt_ntaken_miss", 32'(cnt_ntaken_miss), 32'(e.cn));
        end
    end

    task automatic drain();
        idle("R13 idle");
        while (q.size() > 0) @(posedge clk);
        #2;
    endtask

    task automatic check_reset_state(input string req);
        chk(req, "reset sq_valid", 32'(sq_valid), 0);
        chk(req, "reset done", 32'(done), 0);
        chk(req, "reset trap", 32'(trap), 0);
        chk(req, "reset illegal", 32'(illegal), 0);
        chk(req, "reset keep_slot", 32'(keep_slot), 0);
        chk(req, "reset redirect_pc", 32'(redirect_pc), 0);
        chk(req, "reset cnt_taken_miss", 32'(cnt_taken_miss), 0);
        chk(req, "reset cnt_ntaken_miss", 32'(cnt_ntaken_miss), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("R13");
        rst_n = 1'b1;
        // R11: plain ALU and correctly predicted branch complete
        send(0,0,0,0,0,0,0,0, 2'd1, 8'd5, 16'h0010, 16'h0014, 3'd2, "R11 alu");
        send(0,1,1,0,1,1,0,0, 2'd0, 8'd6, 16'h0020, 16'h0024, 3'd2, "R11 ctrl ok");
        // R10: ALU fault traps
        send(0,0,0,0,0,0,0,1, 2'd2, 8'd7, 16'h0030, 16'h0034, 3'd2, "R10 trap");
        // R1: memory op, even with control/mispredict flags
        send(1,0,0,0,0,0,0,0, 2'd1, 8'd8, 16'h0040, 16'h0044, 3'd2, "R1 mem");
        send(1,1,1,0,1,0,1,0, 2'd1, 8'd9, 16'h0050, 16'h0054, 3'd2, "R1 mem flags");
        // R2: delay-slot conditional, predicted taken
        send(0,1,1,0,1,1,1,0, 2'd1, 8'd10, 16'h0100, 16'h0104, 3'd4, "R2 ds taken");
        // R3: delay-slot conditional, predicted not-taken keeps slot
        send(0,1,1,0,1,0,1,0, 2'd3, 8'd11, 16'h0200, 16'h0204, 3'd5, "R3 ds ntaken");
        // R4: other direct branch, sequence wrap
        send(0,1,1,0,0,1,1,0, 2'd2, 8'd255, 16'h0300, 16'h0304, 3'd1, "R4 direct wrap");
        send(0,1,1,0,0,0,1,0, 2'd0, 8'd20, 16'h0310, 16'h0314, 3'd1, "R4 direct nt");
        // R5: indirect transfer
        send(0,1,0,1,0,0,1,0, 2'd1, 8'd30, 16'h0400, 16'h0404, 3'd3, "R5 indirect");
        idle("R6 pulse end");
        // R9: control fault silenced
        send(0,1,1,0,1,1,1,1, 2'd1, 8'd40, 16'h0500, 16'h0504, 3'd2, "R9 ctrl fault");
        send(0,1,0,0,0,0,0,1, 2'd1, 8'd41, 16'h0500, 16'h0504, 3'd2, "R9 ctrl fault nomp");
        // R12: mispredict on non-direct/indirect
        send(0,1,0,0,0,1,1,0, 2'd1, 8'd42, 16'h0600, 16'h0604, 3'd2, "R12 ctrl none");
        send(0,0,0,0,0,0,1,1, 2'd1, 8'd43, 16'h0600, 16'h0604, 3'd2, "R12 alu mispred");
        idle("R13 idle");
        // R6/R7: back-to-back squashes, different threads and stages
        send(0,1,0,1,0,1,1,0, 2'd3, 8'd50, 16'h0700, 16'h0704, 3'd6, "R6 b2b a");
        send(0,1,1,0,1,0,1,0, 2'd2, 8'd51, 16'h0710, 16'h0714, 3'd7, "R7 b2b b");
        idle("R6 pulse end");
        // R8: saturate the taken counter
        for (int i = 0; i < 9; i++)
            send(0,1,1,0,0,1,1,0, 2'd0, 8'(60 + i), 16'h0800, 16'h0804, 3'd2, "R8 saturate");
        drain();
        chk("R8", "saturated cnt_taken_miss", 32'(cnt_taken_miss), CMAX);
        // R8: reset clears counters
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_state("R8");
        mt = 0; mn = 0;
        rst_n = 1'b1;
        send(0,1,1,0,0,0,1,0, 2'd1, 8'd90, 16'h0900, 16'h0904, 3'd2, "R7 after reset");
        drain();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule